// File: doc/BRIEF.md
# Flash Instruction and Data Fetch Accelerator

This block sits between a processor's 32-bit read port and one bank of slow flash that delivers 128 bits per read. It keeps three line buffers in front of the flash. Instruction fetches use a sequential line buffer and a branch-target line buffer. Data reads use a buffer of their own. Any request that hits a buffer is answered in the same cycle. A request that misses holds the core by keeping `ready_o` low until the line arrives.

While the core runs ahead, the block reads the next flash line into a holding register. That line is only moved into the sequential buffer when the core actually asks for it. A data miss takes the flash from a running prefetch. The prefetch is issued again once the data read has finished. The most recent branch target line is kept apart from the sequential line, so a short loop that keeps branching back to the same place runs without stalls. The number of clocks per flash read comes from a 3-bit register, so it can be matched to the core clock.

Top module: `flash_accel`

## Requirements
- R1: A fetch that hits the sequential or branch-target buffer, or a data read that hits the data buffer, raises `ready_o` in the same cycle. `rdata_o` then carries the word picked by word-address bits [1:0] out of the 128-bit line. Word n sits at line bits [32n+31:32n].
- R2: A request that misses and has no flash read of its line already under way keeps `ready_o` low for exactly T+1 cycles, where T is the effective access time. No request ever waits more than T+1 cycles.
- R3: A fetch of a line that is already being prefetched starts no new flash read. It is served in the first cycle after that prefetch completes.
- R4: When the flash is idle, the block reads the line after the most recently fetched one. With T no greater than 3, straight-line code fetching one word per cycle stalls only on its first line.
- R5: A prefetched line waits in a holding register and is served only when fetched. A fetch miss to any other line discards it, so a later fetch of the discarded line waits the full T+1 cycles.
- R6: A data read that misses aborts a prefetch in progress and waits exactly T+1 cycles. The prefetch is issued again afterwards, so after enough idle cycles the next sequential fetch does not stall.
- R7: Data reads look only at the data buffer, and data fills leave the instruction buffers unchanged. A data read of a line held only for instructions misses, and a later fetch from that line still hits.
- R8: The access time is the 3-bit register value, with 0 treated as 1. `flash_addr_o` stays stable and `flash_req_o` stays high for the whole access.
- R9: Writing the access-time register empties all four buffers and cancels any flash read in progress. A line that was buffered before the write then misses with the new T+1 wait.
- R10: A fetch miss that is not to the line after the last fetched line fills the branch-target buffer. Every iteration of a two-line loop after the first runs without a stall, even at T=7.
- R11: During and after reset, `ready_o` and `flash_req_o` are low, all buffers are empty and the access time is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid; held until ready_o |
| req_fetch_i | input | 1 | 1 = instruction fetch, 0 = data read |
| req_waddr_i | input | 30 | Word address of the request |
| rdata_o | output | 32 | Read word, valid while ready_o is high |
| ready_o | output | 1 | Request served this cycle; low means stall |
| tim_we_i | input | 1 | Write strobe for the access-time register |
| tim_wdata_i | input | 3 | New access time in clocks (0 acts as 1) |
| flash_req_o | output | 1 | Flash read active |
| flash_addr_o | output | 28 | Flash line address |
| flash_rdata_i | input | 128 | Flash line data, sampled on the access's last cycle |

## Verification
On every cycle the assertions check four things. The flash line address stays fixed through an access, and an access ends when its count runs out. A write to the access-time register leaves every buffer empty and the flash idle. A data miss replaces a running prefetch, and a fetch waiting on a matching read never restarts it. The exact wait counts need the bench's scenarios: cold misses, a fetch overtaking its own prefetch, a discarded prefetch, a re-issued prefetch after a data read, and a loop served from the branch-target buffer. The same holds for the data returned under random mixes of fetches, data reads and access times.

// File: rtl/flash_accel_pkg.sv
package flash_accel_pkg;
  typedef enum logic [1:0] {K_PF, K_SEQ, K_BR, K_DAT} fa_kind_e;
  localparam int NBUF = 4;
  localparam int B_PF = 0;  // sequential line
  localparam int B_BT = 1;  // branch target line
  localparam int B_HO = 2;  // prefetch holding line
  localparam int B_DA = 3;  // data line
endpackage

// File: rtl/fa_line_buf.sv
module fa_line_buf #(
  parameter int TAG_W  = 28,
  parameter int LINE_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  logic [LINE_W-1:0] ld_line_i,
  input  logic [TAG_W-1:0]  look_tag_i,
  output logic              hit_o,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [LINE_W-1:0] line_o
);
  logic              v_q;
  logic [TAG_W-1:0]  tag_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      tag_q  <= '0;
      line_q <= '0;
    end else if (ld_i) begin
      v_q    <= 1'b1;
      tag_q  <= ld_tag_i;
      line_q <= ld_line_i;
    end else if (clr_i) begin
      v_q <= 1'b0;
    end
  end

  assign hit_o   = v_q && (tag_q == look_tag_i);
  assign valid_o = v_q;
  assign tag_o   = tag_q;
  assign line_o  = line_q;
endmodule

// File: rtl/fa_flash_seq.sv
module fa_flash_seq
  import flash_accel_pkg::*;
#(
  parameter int TAG_W = 28,
  parameter int TIM_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  fa_kind_e         kind_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TIM_W-1:0] cyc_i,
  output logic             busy_o,
  output logic             done_o,
  output fa_kind_e         kind_o,
  output logic [TAG_W-1:0] tag_o
);
  logic             busy_q;
  logic [TIM_W-1:0] cnt_q;
  logic [TIM_W-1:0] cyc_eff;
  fa_kind_e         kind_q;
  logic [TAG_W-1:0] tag_q;

  assign cyc_eff = (cyc_i == '0) ? TIM_W'(1) : cyc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= K_PF;
      tag_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= cyc_eff - TIM_W'(1);
      kind_q <= kind_i;
      tag_q  <= tag_i;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - TIM_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
  assign kind_o = kind_q;
  assign tag_o  = tag_q;

  a_r8_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && !abort_i && cnt_q != '0) |=> (busy_q && $stable(tag_q)));

  a_r8_access_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !busy_q);
endmodule

// File: rtl/flash_accel.sv
module flash_accel
  import flash_accel_pkg::*;
#(
  parameter int WADDR_W = 30,
  parameter int LINE_W  = 128,
  parameter int WORD_W  = 32,
  parameter int TIM_W   = 3,
  parameter int TIM_RST = 7
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       req_valid_i,
  input  logic                                       req_fetch_i,
  input  logic [WADDR_W-1:0]                         req_waddr_i,
  output logic [WORD_W-1:0]                          rdata_o,
  output logic                                       ready_o,
  input  logic                                       tim_we_i,
  input  logic [TIM_W-1:0]                           tim_wdata_i,
  output logic                                       flash_req_o,
  output logic [WADDR_W-$clog2(LINE_W/WORD_W)-1:0]   flash_addr_o,
  input  logic [LINE_W-1:0]                          flash_rdata_i
);
  localparam int WPL   = LINE_W / WORD_W;
  localparam int SEL_W = $clog2(WPL);
  localparam int TAG_W = WADDR_W - SEL_W;

  logic [TIM_W-1:0] tim_q;
  logic             inval;
  logic [TAG_W-1:0] req_tag;
  logic [SEL_W-1:0] req_sel;

  logic              buf_clr  [NBUF];
  logic              buf_ld   [NBUF];
  logic [TAG_W-1:0]  buf_ldtag[NBUF];
  logic [LINE_W-1:0] buf_ldln [NBUF];
  logic              buf_hit  [NBUF];
  logic              buf_v    [NBUF];
  logic [TAG_W-1:0]  buf_tag  [NBUF];
  logic [LINE_W-1:0] buf_line [NBUF];
  logic [WORD_W-1:0] buf_word [NBUF];

  logic             fl_busy, fl_done, fl_start, fl_abort;
  fa_kind_e         fl_kind, st_kind;
  logic [TAG_W-1:0] fl_tag, st_tag;

  logic             cur_v, cur_nxt_v;
  logic [TAG_W-1:0] cur_tag, cur_nxt, pf_tgt;

  logic fetch, dat, hit_pf, hit_bt, hit_ho, hit_da, served_f;
  logic miss, pend, dem_start, seq, pf_in, pf_start, cmp;
  fa_kind_e dem_kind;

  assign inval   = tim_we_i;
  assign req_tag = req_waddr_i[WADDR_W-1:SEL_W];
  assign req_sel = req_waddr_i[SEL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tim_q <= TIM_W'(TIM_RST);
    else if (tim_we_i) tim_q <= tim_wdata_i;
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    fa_line_buf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_buf (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (buf_clr[g]),
      .ld_i       (buf_ld[g]),
      .ld_tag_i   (buf_ldtag[g]),
      .ld_line_i  (buf_ldln[g]),
      .look_tag_i (req_tag),
      .hit_o      (buf_hit[g]),
      .valid_o    (buf_v[g]),
      .tag_o      (buf_tag[g]),
      .line_o     (buf_line[g])
    );
    assign buf_word[g] = buf_line[g][req_sel*WORD_W +: WORD_W];
  end

  // hit detection, instruction buffers and data buffer kept apart
  assign fetch    = req_valid_i && req_fetch_i;
  assign dat      = req_valid_i && !req_fetch_i;
  assign hit_pf   = fetch && buf_hit[B_PF];
  assign hit_bt   = fetch && buf_hit[B_BT] && !hit_pf;
  assign hit_ho   = fetch && buf_hit[B_HO] && !hit_pf && !hit_bt;
  assign hit_da   = dat && buf_hit[B_DA];
  assign served_f = hit_pf || hit_bt || hit_ho;
  assign ready_o  = served_f || hit_da;

  always_comb begin
    rdata_o = '0;
    if (hit_pf)      rdata_o = buf_word[B_PF];
    else if (hit_bt) rdata_o = buf_word[B_BT];
    else if (hit_ho) rdata_o = buf_word[B_HO];
    else if (hit_da) rdata_o = buf_word[B_DA];
  end

  // miss handling
  assign miss      = req_valid_i && !ready_o;
  assign pend      = fl_busy && (fl_tag == req_tag) &&
                     (req_fetch_i ? (fl_kind != K_DAT) : (fl_kind == K_DAT));
  assign dem_start = miss && !pend && !inval;
  assign seq       = cur_v && (req_tag == cur_tag + TAG_W'(1));
  assign dem_kind  = !req_fetch_i ? K_DAT : (seq ? K_SEQ : K_BR);

  // next-line prefetch follows the line being fetched now
  assign cur_nxt_v = cur_v || served_f;
  assign cur_nxt   = served_f ? req_tag : cur_tag;
  assign pf_tgt    = cur_nxt + TAG_W'(1);

  always_comb begin
    pf_in = 1'b0;
    for (int k = B_PF; k <= B_HO; k++)
      if (buf_v[k] && buf_tag[k] == pf_tgt) pf_in = 1'b1;
  end

  assign pf_start = !fl_busy && cur_nxt_v && !pf_in && !miss && !inval;
  assign fl_start = dem_start || pf_start;
  assign st_kind  = dem_start ? dem_kind : K_PF;
  assign st_tag   = dem_start ? req_tag : pf_tgt;
  assign fl_abort = (dem_start && fl_busy) || inval;
  assign cmp      = fl_done && !fl_abort;

  fa_flash_seq #(.TAG_W(TAG_W), .TIM_W(TIM_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (fl_start),
    .abort_i (fl_abort),
    .kind_i  (st_kind),
    .tag_i   (st_tag),
    .cyc_i   (tim_q),
    .busy_o  (fl_busy),
    .done_o  (fl_done),
    .kind_o  (fl_kind),
    .tag_o   (fl_tag)
  );

  assign flash_req_o  = fl_busy;
  assign flash_addr_o = fl_tag;

  // buffer fills
  always_comb begin
    for (int k = 0; k < NBUF; k++) begin
      buf_clr[k]   = inval;
      buf_ldtag[k] = fl_tag;
      buf_ldln[k]  = flash_rdata_i;
    end
    buf_ld[B_BT] = cmp && fl_kind == K_BR;
    buf_ld[B_HO] = cmp && fl_kind == K_PF;
    buf_ld[B_DA] = cmp && fl_kind == K_DAT;
    buf_ld[B_PF] = (cmp && fl_kind == K_SEQ) || (hit_ho && !inval);
    if (!(cmp && fl_kind == K_SEQ)) begin
      buf_ldtag[B_PF] = buf_tag[B_HO];
      buf_ldln[B_PF]  = buf_line[B_HO];
    end
    buf_clr[B_HO] = inval || hit_ho || (dem_start && req_fetch_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_v   <= 1'b0;
      cur_tag <= '0;
    end else if (inval) begin
      cur_v   <= 1'b0;
    end else begin
      cur_v   <= cur_nxt_v;
      cur_tag <= cur_nxt;
    end
  end

  a_r9_inval_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tim_we_i |=> (!buf_v[B_PF] && !buf_v[B_BT] && !buf_v[B_HO] && !buf_v[B_DA] && !fl_busy));

  a_r6_dat_takes_flash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat && !buf_hit[B_DA] && fl_busy && fl_kind == K_PF && !tim_we_i)
      |=> (fl_busy && fl_kind == K_DAT));

  a_r3_wait_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss && pend && !fl_done && !tim_we_i) |=> (fl_busy && $stable(fl_tag)));
endmodule

// File: tb/sim_flash_accel.sv
module sim_flash_accel;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_fetch = 1'b0;
  logic [29:0]  req_waddr = '0;
  logic [31:0]  rdata;
  logic         ready;
  logic         tim_we = 1'b0;
  logic [2:0]   tim_wdata = '0;
  logic         flash_req;
  logic [27:0]  flash_addr;
  logic [127:0] flash_rdata;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  flash_accel u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_fetch_i(req_fetch),
    .req_waddr_i(req_waddr), .rdata_o(rdata), .ready_o(ready), .tim_we_i(tim_we),
    .tim_wdata_i(tim_wdata), .flash_req_o(flash_req), .flash_addr_o(flash_addr),
    .flash_rdata_i(flash_rdata)
  );

  function automatic logic [31:0] mword(input logic [29:0] wa);
    return (32'(wa) * 32'h9E3779B1) ^ 32'h13572468;
  endfunction

  always_comb
    for (int g = 0; g < 4; g++) flash_rdata[g*32 +: 32] = mword({flash_addr, 2'(g)});

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [29:0] wa, input logic f, output int st, output logic [31:0] d);
    st = 0;
    req_valid = 1'b1; req_waddr = wa; req_fetch = f;
    #1;
    while (ready !== 1'b1 && st < 64) begin
      st++;
      @(negedge clk); #1;
    end
    d = rdata;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fx(input string req, input logic [29:0] wa, input logic f, input int exp_st);
    int st;
    logic [31:0] d;
    acc(wa, f, st, d);
    check({req, " data"}, d, mword(wa));
    check({req, " stall"}, st, exp_st);
  endtask

  task automatic set_tim(input logic [2:0] t);
    tim_we = 1'b1; tim_wdata = t;
    @(negedge clk);
    tim_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int st, t, lp;
    logic [31:0] d;
    logic [29:0] wa;
    logic f;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 ready in reset", ready, 1'b0);
    check("R11 flash_req in reset", flash_req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 flash idle after reset", flash_req, 1'b0);
    fx("R11 R2 cold miss at T=7", 30'h0050, 1'b1, 8);

    // R4 straight line at T=3, R1 same-cycle hits
    set_tim(3'd3);
    fx("R4 R2 first line", 30'h0040, 1'b1, 4);
    for (int i = 1; i < 16; i++) fx("R4 R1 sequential", 30'h0040 + 30'(i), 1'b1, 0);

    // R3 fetch catches its own prefetch
    set_tim(3'd7);
    fx("R3 R2 cold", 30'h0100, 1'b1, 8);
    idle(4);
    fx("R3 pending prefetch", 30'h0104, 1'b1, 3);

    // R5 holding line discarded by a different fetch miss
    set_tim(3'd7);
    fx("R5 cold", 30'h0200, 1'b1, 8);
    idle(12);
    fx("R5 other line", 30'h0300, 1'b1, 8);
    fx("R5 discarded line", 30'h0206, 1'b1, 8);

    // R6 data read aborts and re-issues prefetch
    set_tim(3'd7);
    fx("R6 cold fetch", 30'h0400, 1'b1, 8);
    fx("R6 data abort", 30'h0800, 1'b0, 8);
    idle(10);
    fx("R6 prefetch reissued", 30'h0404, 1'b1, 0);

    // R7 separate data buffer
    fx("R7 data misses ibuf line", 30'h0401, 1'b0, 8);
    fx("R7 ibuf kept", 30'h0405, 1'b1, 0);
    fx("R7 data buffer hit", 30'h0402, 1'b0, 0);

    // R10 loop through branch-target buffer at T=7
    set_tim(3'd7);
    for (int it = 0; it < 3; it++) begin
      lp = 0;
      for (int w = 0; w < 8; w++) begin
        acc(30'h0600 + 30'(w), 1'b1, st, d);
        check("R10 loop data", d, mword(30'h0600 + 30'(w)));
        lp += st;
      end
      check(it == 0 ? "R10 first pass stalls" : "R10 repeat pass stalls", lp, it == 0 ? 12 : 0);
    end

    // R9 access-time write empties buffers
    set_tim(3'd5);
    fx("R9 invalidated loop line", 30'h0600, 1'b1, 6);

    // R8 zero acts as one clock
    set_tim(3'd0);
    fx("R8 T=0 miss", 30'h0A00, 1'b1, 2);
    fx("R8 T=0 hit", 30'h0A01, 1'b1, 0);

    // random mix, R1 data and R2 wait bound
    t = 1;
    for (int i = 0; i < 150; i++) begin
      if (i % 50 == 0) begin
        t = 1 + int'($urandom_range(0, 6));
        set_tim(3'(t));
      end
      wa = 30'h3000 + 30'($urandom_range(0, 47));
      f  = ($urandom_range(0, 2) != 0);
      acc(wa, f, st, d);
      check("R1 random data", d, mword(wa));
      check("R2 random wait bound", 32'(st <= t + 1), 32'd1);
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 6)));
    end

    summary();
    $finish;
  end
endmodule